// File: doc/BRIEF.md
# Engine Reset and Bridge Port Sequencer

This controller takes one engine inside an island that is already powered and moves it between out-of-service and in-service. It owns the engine's clock enable, its active-low reset and the stop request lines of the engine's two bridge ports, a master-side port and a slave-side port. Each port answers a stop request by raising an acknowledge and a release by dropping it.

A single-cycle request starts a sequence: bring up, take down, or a reset that takes the engine down and brings it back up. The block reports the outcome with a one-cycle done or error pulse. Every handshake has a cycle budget. A failed step undoes the steps already taken in that sequence. When an engine has no bridge ports (`HAS_PORTS = 0`), the block only sequences the clock and the reset.

Top module: `subdomain_seq`

## Requirements
- R1: After reset the clock enable is 0, the engine reset is asserted (`eng_rst_n` = 0, `rst_held` = 1), both stop lines are 1, and done, error and busy are 0.
- R2: Bring-up drives the clock enable high for exactly `PROP_CYCLES` cycles while the reset is held. It then gates the clock and releases the reset while the clock is gated. After that it enables the clock again. Without ports, done follows the request by `PROP_CYCLES` + 3 cycles.
- R3: During bring-up the master stop line is released before the slave stop line. Each release counts as complete only when that port's acknowledge reads 0. A successful bring-up ends with the clock enabled, the reset released and both stop lines at 0.
- R4: A handshake fails when its acknowledge has not changed within `ACK_TIMEOUT` cycles. If the master release fails, the block re-asserts the master stop, gates the clock, asserts the reset one cycle later and pulses error. The error comes 36 + `ACK_TIMEOUT` cycles after the request when `PROP_CYCLES` = 32.
- R5: If the slave release fails, the block re-asserts both stop lines and waits for the master acknowledge, or for the budget to run out. It then gates the clock, asserts the reset and pulses error.
- R6: Take-down stops the slave port, then the master port, waiting for each acknowledge to rise. It then gates the clock, then asserts the reset in the next cycle, and pulses done. From an already stopped engine, done comes 4 cycles after the request.
- R7: If the slave stop fails during take-down, the block withdraws the slave stop and pulses error. If the master stop fails, it withdraws both stop lines, waits for the slave acknowledge to drop, and pulses error. In both cases the engine keeps its clock and stays out of reset.
- R8: A reset request runs a full take-down followed by a full bring-up, and the engine reset is asserted between the two. Without ports, a reset request pulses error one cycle after the request and changes no output.
- R9: Without ports, both stop lines stay at 1 at all times.
- R10: Requests that arrive while a sequence is running are ignored. Of requests that arrive in the same idle cycle, take-down wins over reset, and reset wins over bring-up.
- R11: Done and error are single-cycle pulses and are never high together. Busy is 0 in the cycle they are shown. `rst_held` is 1 exactly when the engine reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer |
| req_on | input | 1 | Bring-up request pulse |
| req_off | input | 1 | Take-down request pulse |
| req_reset | input | 1 | Engine reset request pulse |
| mst_ack | input | 1 | Master port acknowledge, 1 when stopped |
| slv_ack | input | 1 | Slave port acknowledge, 1 when stopped |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Sequence finished successfully (pulse) |
| err | output | 1 | Sequence failed and was rolled back (pulse) |
| eng_clk_en | output | 1 | Engine clock enable |
| eng_rst_n | output | 1 | Engine reset, active low |
| mst_stop | output | 1 | Master port stop request |
| slv_stop | output | 1 | Slave port stop request |
| rst_held | output | 1 | Engine reset currently asserted |

## Verification
Two kinds of coincidence are provoked. In the first, a take-down request and a bring-up request arrive in the same idle cycle. The take-down must win, which the bench judges by the stopped final state and a 4-cycle completion. In the second, a take-down request arrives in the middle of a running bring-up. It must vanish, which the bench judges by a single completion carrying the running-engine state and no further done or error pulse afterwards. A bridge model that can freeze either acknowledge drives each failure path, and the scoreboard compares the final output state and the completion latency of every path.

// File: rtl/subdomain_seq.sv
module subdomain_seq #(
  parameter int PROP_CYCLES = 32,
  parameter int ACK_TIMEOUT = 100,
  parameter bit HAS_PORTS   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_on,
  input  logic req_off,
  input  logic req_reset,
  input  logic mst_ack,
  input  logic slv_ack,
  output logic busy,
  output logic done,
  output logic err,
  output logic eng_clk_en,
  output logic eng_rst_n,
  output logic mst_stop,
  output logic slv_stop,
  output logic rst_held
);
  localparam int CMAX = (PROP_CYCLES > ACK_TIMEOUT) ? PROP_CYCLES : ACK_TIMEOUT;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] PROP_LAST = CW'(PROP_CYCLES - 1);
  localparam logic [CW-1:0] ACK_LAST  = CW'(ACK_TIMEOUT - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PULSE, S_UNRST, S_CLKON, S_MREL, S_SREL, S_RBM, S_FAILRST,
    S_SSTOP, S_MSTOP, S_RBS, S_OFFRST, S_REON
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic          rmode;
  logic          expired;

  assign busy     = (st != S_IDLE);
  assign rst_held = ~eng_rst_n;
  assign expired  = (cnt == ACK_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; rmode <= 1'b0;
      done <= 1'b0; err <= 1'b0;
      eng_clk_en <= 1'b0; eng_rst_n <= 1'b0;
      mst_stop <= 1'b1; slv_stop <= 1'b1;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_off || (req_reset && HAS_PORTS)) begin
            rmode <= !req_off;
            cnt   <= '0;
            if (HAS_PORTS) begin
              slv_stop <= 1'b1;
              st <= S_SSTOP;
            end else begin
              eng_clk_en <= 1'b0;
              st <= S_OFFRST;
            end
          end else if (req_reset) begin
            err <= 1'b1;
          end else if (req_on) begin
            eng_clk_en <= 1'b1;
            cnt <= '0;
            st  <= S_PULSE;
          end
        end
        S_PULSE: begin
          if (cnt == PROP_LAST) begin
            eng_clk_en <= 1'b0;
            st <= S_UNRST;
          end else cnt <= cnt + 1'b1;
        end
        S_UNRST: begin
          eng_rst_n <= 1'b1;
          st <= S_CLKON;
        end
        S_CLKON: begin
          eng_clk_en <= 1'b1;
          rmode <= 1'b0;
          cnt <= '0;
          if (HAS_PORTS) begin
            mst_stop <= 1'b0;
            st <= S_MREL;
          end else begin
            done <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_MREL: begin
          if (!mst_ack) begin
            slv_stop <= 1'b0;
            cnt <= '0;
            st  <= S_SREL;
          end else if (expired) begin
            mst_stop <= 1'b1;
            eng_clk_en <= 1'b0;
            st <= S_FAILRST;
          end else cnt <= cnt + 1'b1;
        end
        S_SREL: begin
          if (!slv_ack) begin
            done <= 1'b1;
            st <= S_IDLE;
          end else if (expired) begin
            slv_stop <= 1'b1;
            mst_stop <= 1'b1;
            cnt <= '0;
            st  <= S_RBM;
          end else cnt <= cnt + 1'b1;
        end
        S_RBM: begin
          if (mst_ack || expired) begin
            eng_clk_en <= 1'b0;
            st <= S_FAILRST;
          end else cnt <= cnt + 1'b1;
        end
        S_FAILRST: begin
          eng_rst_n <= 1'b0;
          err <= 1'b1;
          st  <= S_IDLE;
        end
        S_SSTOP: begin
          if (slv_ack) begin
            mst_stop <= 1'b1;
            cnt <= '0;
            st  <= S_MSTOP;
          end else if (expired) begin
            slv_stop <= 1'b0;
            rmode <= 1'b0;
            err <= 1'b1;
            st  <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_MSTOP: begin
          if (mst_ack) begin
            eng_clk_en <= 1'b0;
            st <= S_OFFRST;
          end else if (expired) begin
            mst_stop <= 1'b0;
            slv_stop <= 1'b0;
            cnt <= '0;
            st  <= S_RBS;
          end else cnt <= cnt + 1'b1;
        end
        S_RBS: begin
          if (!slv_ack || expired) begin
            rmode <= 1'b0;
            err <= 1'b1;
            st  <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_OFFRST: begin
          eng_rst_n <= 1'b0;
          if (rmode) st <= S_REON;
          else begin
            done <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_REON: begin
          eng_clk_en <= 1'b1;
          cnt <= '0;
          st  <= S_PULSE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/subdomain_seq_chk.sv
module subdomain_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic eng_clk_en,
  input logic eng_rst_n,
  input logic mst_stop,
  input logic slv_stop
);
  // R11
  result_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));

  // R11
  result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);

  // R2
  release_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_rst_n) |-> !eng_clk_en);

  // R6
  assert_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_rst_n) |-> (!eng_clk_en && mst_stop && slv_stop));

  // R3
  master_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slv_stop) |-> !mst_stop);

  // R5
  slave_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mst_stop) |-> slv_stop);
endmodule

bind subdomain_seq subdomain_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .eng_clk_en(eng_clk_en), .eng_rst_n(eng_rst_n),
  .mst_stop(mst_stop), .slv_stop(slv_stop)
);

// File: tb/subdomain_seq_test.sv
module subdomain_seq_test;
  localparam int T = 100;
  localparam int P = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] r_on = '0, r_off = '0, r_rst = '0;
  logic m_hang = 1'b0, s_hang = 1'b0;
  logic [2:0] mpipe, spipe;
  logic m_ack, s_ack;

  logic busy0, done0, err0, clk0, rstn0, ms0, ss0, held0;
  logic busy1, done1, err1, clk1, rstn1, ms1, ss1, held1;

  subdomain_seq #(.PROP_CYCLES(P), .ACK_TIMEOUT(T), .HAS_PORTS(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_on(r_on[0]), .req_off(r_off[0]), .req_reset(r_rst[0]),
    .mst_ack(m_ack), .slv_ack(s_ack), .busy(busy0), .done(done0), .err(err0),
    .eng_clk_en(clk0), .eng_rst_n(rstn0), .mst_stop(ms0), .slv_stop(ss0), .rst_held(held0));

  subdomain_seq #(.PROP_CYCLES(P), .ACK_TIMEOUT(T), .HAS_PORTS(1'b0)) uut_np (
    .clk(clk), .rst_n(rst_n), .req_on(r_on[1]), .req_off(r_off[1]), .req_reset(r_rst[1]),
    .mst_ack(1'b0), .slv_ack(1'b0), .busy(busy1), .done(done1), .err(err1),
    .eng_clk_en(clk1), .eng_rst_n(rstn1), .mst_stop(ms1), .slv_stop(ss1), .rst_held(held1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpipe <= '1; spipe <= '1; m_ack <= 1'b1; s_ack <= 1'b1;
    end else begin
      mpipe <= {mpipe[1:0], ms0};
      spipe <= {spipe[1:0], ss0};
      if (!m_hang) m_ack <= mpipe[2];
      if (!s_hang) s_ack <= spipe[2];
    end
  end

  int checks = 0, errors = 0, cyc = 0, last_cyc = 0;
  int hi_run = 0, hi_len = 0;
  logic seen_rst_low = 1'b0;
  logic [5:0] q[$];
  string tq[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic take(input bit inst, input logic [4:0] act);
    logic [5:0] it;
    string tg;
    if (q.size() == 0) begin
      check(1'b0, "R10 unexpected result pulse", int'({inst, act}), 0);
    end else begin
      it = q.pop_front();
      tg = tq.pop_front();
      check({inst, act} == it, tg, int'({inst, act}), int'(it));
      last_cyc = cyc;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done0 || err0) take(1'b0, {err0, clk0, rstn0, ms0, ss0});
      if (done1 || err1) take(1'b1, {err1, clk1, rstn1, ms1, ss1});
      if (!rstn0) seen_rst_low = 1'b1;
      if (clk1) hi_run++;
      else if (hi_run != 0) begin hi_len = hi_run; hi_run = 0; end
    end
  end

  task automatic run(input bit inst, input bit on, input bit off, input bit rs,
                     input logic [4:0] ex, input string tag, output int lat);
    int t0;
    q.push_back({inst, ex});
    tq.push_back(tag);
    @(negedge clk);
    t0 = cyc;
    r_on[inst] = on; r_off[inst] = off; r_rst[inst] = rs;
    @(negedge clk);
    r_on = '0; r_off = '0; r_rst = '0;
    while (q.size() > 0) @(negedge clk);
    lat = last_cyc - t0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check({clk0, rstn0, ms0, ss0, held0} == 5'b00111, "R1 reset outputs",
          int'({clk0, rstn0, ms0, ss0, held0}), 7);
    check({busy0, done0, err0} == 3'b000, "R1 reset status", int'({busy0, done0, err0}), 0);

    // R10: take-down and bring-up in the same cycle, take-down wins
    run(1'b0, 1'b1, 1'b1, 1'b0, 5'b00011, "R10 off beats on", lat);
    check(lat == 4, "R6 R10 off latency", lat, 4);

    // R4: master release hangs
    m_hang = 1'b1;
    run(1'b0, 1'b1, 1'b0, 1'b0, 5'b10011, "R4 master release fail", lat);
    check(lat == 36 + T, "R4 timeout latency", lat, 36 + T);
    m_hang = 1'b0;

    // R5: slave release hangs
    s_hang = 1'b1;
    run(1'b0, 1'b1, 1'b0, 1'b0, 5'b10011, "R5 slave release fail", lat);
    s_hang = 1'b0;

    // R2 R3 R10: normal bring-up with a take-down injected while busy
    q.push_back({1'b0, 5'b01100});
    tq.push_back("R3 bring-up result");
    @(negedge clk);
    r_on[0] = 1'b1;
    @(negedge clk);
    r_on = '0;
    repeat (5) @(negedge clk);
    r_off[0] = 1'b1;
    @(negedge clk);
    r_off = '0;
    while (q.size() > 0) @(negedge clk);
    repeat (40) @(negedge clk);
    check(clk0 && rstn0 && !ms0 && !ss0, "R10 ignored request left engine on",
          int'({clk0, rstn0, ms0, ss0}), 12);

    // R7: master stop hangs during take-down
    m_hang = 1'b1;
    run(1'b0, 1'b0, 1'b1, 1'b0, 5'b11100, "R7 master stop fail", lat);
    m_hang = 1'b0;

    // R7: slave stop hangs during take-down
    s_hang = 1'b1;
    run(1'b0, 1'b0, 1'b1, 1'b0, 5'b11100, "R7 slave stop fail", lat);
    s_hang = 1'b0;

    // R8: reset request cycles the engine
    seen_rst_low = 1'b0;
    run(1'b0, 1'b0, 1'b0, 1'b1, 5'b01100, "R8 reset request", lat);
    check(seen_rst_low, "R8 reset asserted in between", int'(seen_rst_low), 1);
    check(!held0, "R11 reset level while running", int'(held0), 0);

    // R6: normal take-down
    run(1'b0, 1'b0, 1'b1, 1'b0, 5'b00011, "R6 take-down", lat);
    check(held0, "R11 reset level after take-down", int'(held0), 1);

    // R9 R2: no-port engine
    run(1'b1, 1'b1, 1'b0, 1'b0, 5'b01111, "R9 no-port bring-up", lat);
    check(lat == P + 3, "R9 no-port latency", lat, P + 3);
    check(hi_len == P, "R2 propagation pulse width", hi_len, P);

    // R8 R10: reset refused without ports, beats bring-up
    run(1'b1, 1'b1, 1'b0, 1'b1, 5'b11111, "R8 no-port reset refused", lat);
    check(lat == 1, "R8 refusal latency", lat, 1);

    run(1'b1, 1'b0, 1'b1, 1'b0, 5'b00011, "R9 no-port take-down", lat);
    check(ms1 && ss1, "R9 stop lines untouched", int'({ms1, ss1}), 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule